// File: doc/BRIEF.md
# Zero-Block Pointer Run-Length Codec

This block limits long runs of equal bits in a 79-bit scrambled word by turning it into an 80-bit coded word, and it turns such a coded word back into the original 79 bits. The encoder puts a marker bit of value 1 in front of the data and treats the 80 bits as sixteen 5-bit slots. Slot 0 is the most significant slot, and the marker is its top bit. Each slot that holds only zeros is taken out of the data path by a pointer chain that starts in slot 0. After that, each slot that holds only ones is rewritten as zeros. The decoder undoes both steps in the reverse order.

The two directions are independent engines inside one top module. Each engine has its own start/done handshake and its own data ports, and both can run at once. Each engine handles one slot per clock in two fixed passes, so its latency does not depend on the data.

Top module: `zblk_rll_codec`

## Requirements
- R1: Slot k of a word covers bits [79-5k : 75-5k]. The encoder forms {1'b1, enc_data_in}. If that word has no 00000 slot and no 11111 slot, enc_data_out equals it unchanged.
- R2: The encoder walks slots 1 to 15 in ascending order, with a chain head that starts at slot 0. For each 00000 slot i, the head's current content is copied into slot i, the head receives the 5-bit index of i (top bit 0), and i becomes the new head. As a result, slot 0 of the output holds the index of the lowest all-zero slot.
- R3: After the pointer pass, every 11111 slot of the encoder word becomes 00000. No coded output slot equals 11111.
- R4: For every 79-bit value x, decoding the encoding of x returns x.
- R5: The decoder first rewrites every 00000 slot as 11111. While the top bit of slot 0 is 0, slot 0 is used as a pointer z: slot 0 takes the content of slot z, and slot z is cleared. When the top bit of slot 0 is 1, dec_data_out is bits [78:0] of the word.
- R6: Each engine raises its done output for exactly one cycle. This happens 32 rising edges (2 × 16) after the edge that accepts its start.
- R7: A start that arrives while the engine is busy, including the cycle in which done is high, is ignored. It neither restarts nor changes the running job.
- R8: After reset both done outputs are 0 and both data outputs are zero. A data output holds its value from done until the next accepted start.
- R9: The encoder and the decoder can run in the same cycles on unrelated data without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_start | input | 1 | Starts an encode when the encoder is idle |
| enc_data_in | input | 79 | Scrambled word to encode |
| enc_done | output | 1 | One-cycle pulse when the encoded word is ready |
| enc_data_out | output | 80 | Coded word |
| dec_start | input | 1 | Starts a decode when the decoder is idle |
| dec_data_in | input | 80 | Coded word to decode |
| dec_done | output | 1 | One-cycle pulse when the decoded word is ready |
| dec_data_out | output | 79 | Recovered word |

## Verification
Two events can land in the same cycle. One is a fresh start coinciding with an engine's own done pulse, which must be dropped rather than taken as a new job. The other is the encoder and the decoder finishing together while working on different words. The bench launches both engines in one cycle and pokes start again both in mid-pass and exactly in the done cycle. It then judges the result by counting done pulses at the ports and by comparing each output with an independently computed expected word.

// File: rtl/zrl_pkg.sv
package zrl_pkg;
  localparam int SB_W   = 5;
  localparam int NUM_SB = 1 << (SB_W - 1);
  localparam int WORD_W = SB_W * NUM_SB;
  localparam int DATA_W = WORD_W - 1;
  localparam int IDX_W  = SB_W - 1;
  localparam int LAT    = 2 * NUM_SB;

  typedef logic [SB_W-1:0] sb_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PASS1 = 2'd1,
    PH_PASS2 = 2'd2,
    PH_FIN   = 2'd3
  } phase_e;

  function automatic logic sb_is_zero(input sb_t s);
    return s == '0;
  endfunction

  function automatic logic sb_is_ones(input sb_t s);
    return &s;
  endfunction

  function automatic sb_t slot_of(input logic [WORD_W-1:0] w, input int k);
    return w[WORD_W-1-SB_W*k -: SB_W];
  endfunction

  function automatic logic any_ones_slot(input logic [WORD_W-1:0] w);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NUM_SB; k++) hit |= sb_is_ones(slot_of(w, k));
    return hit;
  endfunction
endpackage

// File: rtl/zrl_seq.sv
module zrl_seq
  import zrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SB - 1);

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_PASS1;
          idx_q   <= '0;
        end
        PH_PASS1: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) phase_q <= PH_PASS2;
        end
        PH_PASS2: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) phase_q <= PH_FIN;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign idx_o    = idx_q;
  assign accept_o = (phase_q == PH_IDLE) && start_i;
  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = (phase_q == PH_FIN);
endmodule

// File: rtl/zrl_encoder.sv
module zrl_encoder
  import zrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic [WORD_W-1:0] data_o,
  output logic              accept_o,
  output logic              busy_o
);
  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] head_q;
  sb_t              slot_q [NUM_SB];
  logic             ptr_write;
  logic             ones_clear;

  zrl_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .phase_o (phase),
    .idx_o   (idx),
    .accept_o(accept_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  // pass 1 links an all-zero slot into the chain; pass 2 clears all-ones slots
  assign ptr_write  = (phase == PH_PASS1) && (idx != '0) && sb_is_zero(slot_q[idx]);
  assign ones_clear = (phase == PH_PASS2) && sb_is_ones(slot_q[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SB; k++) slot_q[k] <= '0;
      head_q <= '0;
    end else if (accept_o) begin
      slot_q[0] <= {1'b1, data_i[DATA_W-1 -: IDX_W]};
      for (int k = 1; k < NUM_SB; k++) slot_q[k] <= data_i[WORD_W-1-SB_W*k -: SB_W];
      head_q <= '0;
    end else if (ptr_write) begin
      slot_q[idx]    <= slot_q[head_q];
      slot_q[head_q] <= {1'b0, idx};
      head_q         <= idx;
    end else if (ones_clear) begin
      slot_q[idx] <= '0;
    end
  end

  always_comb begin
    data_o = '0;
    for (int k = 0; k < NUM_SB; k++) data_o[WORD_W-1-SB_W*k -: SB_W] = slot_q[k];
  end
endmodule

// File: rtl/zrl_decoder.sv
module zrl_decoder
  import zrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              accept_o,
  output logic              busy_o
);
  phase_e           phase;
  logic [IDX_W-1:0] idx;
  sb_t              slot_q [NUM_SB];
  logic             zero_fill;
  logic             follow;
  logic [IDX_W-1:0] target;

  zrl_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .phase_o (phase),
    .idx_o   (idx),
    .accept_o(accept_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  // pass 1 restores mapped all-ones slots; pass 2 unwinds the chain from slot 0
  assign zero_fill = (phase == PH_PASS1) && sb_is_zero(slot_q[idx]);
  assign follow    = (phase == PH_PASS2) && !slot_q[0][SB_W-1];
  assign target    = slot_q[0][IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SB; k++) slot_q[k] <= '0;
    end else if (accept_o) begin
      for (int k = 0; k < NUM_SB; k++) slot_q[k] <= slot_of(data_i, k);
    end else if (zero_fill) begin
      slot_q[idx] <= '1;
    end else if (follow) begin
      slot_q[0]      <= slot_q[target];
      slot_q[target] <= '0;
    end
  end

  always_comb begin
    data_o = '0;
    data_o[DATA_W-1 -: IDX_W] = slot_q[0][IDX_W-1:0];
    for (int k = 1; k < NUM_SB; k++) data_o[WORD_W-1-SB_W*k -: SB_W] = slot_q[k];
  end
endmodule

// File: rtl/zblk_rll_codec.sv
module zblk_rll_codec
  import zrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_start,
  input  logic [DATA_W-1:0] enc_data_in,
  output logic              enc_done,
  output logic [WORD_W-1:0] enc_data_out,
  input  logic              dec_start,
  input  logic [WORD_W-1:0] dec_data_in,
  output logic              dec_done,
  output logic [DATA_W-1:0] dec_data_out
);
  logic enc_accept;
  logic enc_busy;
  logic dec_accept;
  logic dec_busy;

  zrl_encoder u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (enc_start),
    .data_i  (enc_data_in),
    .done_o  (enc_done),
    .data_o  (enc_data_out),
    .accept_o(enc_accept),
    .busy_o  (enc_busy)
  );

  zrl_decoder u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (dec_start),
    .data_i  (dec_data_in),
    .done_o  (dec_done),
    .data_o  (dec_data_out),
    .accept_o(dec_accept),
    .busy_o  (dec_busy)
  );
endmodule

// File: rtl/zblk_rll_checker.sv
module zblk_rll_checker
  import zrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enc_done,
  input logic [WORD_W-1:0] enc_data_out,
  input logic              dec_done,
  input logic [DATA_W-1:0] dec_data_out,
  input logic              enc_accept,
  input logic              enc_busy,
  input logic              dec_accept,
  input logic              dec_busy
);
  localparam int CW = $clog2(LAT) + 2;

  logic [CW-1:0] enc_age;
  logic [CW-1:0] dec_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_age <= '0;
      dec_age <= '0;
    end else begin
      if (enc_accept) enc_age <= '0;
      else if (enc_busy && enc_age != '1) enc_age <= enc_age + 1'b1;
      if (dec_accept) dec_age <= '0;
      else if (dec_busy && dec_age != '1) dec_age <= dec_age + 1'b1;
    end
  end

  assert_enc_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done |=> !enc_done);
  assert_dec_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> !dec_done);
  assert_enc_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done |-> enc_age == CW'(LAT));
  assert_dec_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> dec_age == CW'(LAT));
  assert_no_ones_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done |-> !any_ones_slot(enc_data_out));
  assert_enc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_busy && !$past(enc_busy)) |-> $stable(enc_data_out));
  assert_dec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_busy && !$past(dec_busy)) |-> $stable(dec_data_out));
endmodule

bind zblk_rll_codec zblk_rll_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enc_done    (enc_done),
  .enc_data_out(enc_data_out),
  .dec_done    (dec_done),
  .dec_data_out(dec_data_out),
  .enc_accept  (enc_accept),
  .enc_busy    (enc_busy),
  .dec_accept  (dec_accept),
  .dec_busy    (dec_busy)
);

// File: tb/zblk_rll_codec_bench.sv
module zblk_rll_codec_bench;
  import zrl_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [DATA_W-1:0] din;
    logic [SB_W-1:0]   head;
  } vec_t;

  // stimulus with the hand-worked expected slot 0 of the coded word
  localparam vec_t VECS [7] = '{
    '{ {DATA_W{1'b0}}, 5'b00001 },
    '{ {DATA_W{1'b1}}, 5'b00000 },
    '{ {4'b0101, {7{10'b0000010101}}, 5'b00000}, 5'b00001 },
    '{ {4'b1111, {15{5'b01010}}}, 5'b00000 },
    '{ {4'b0011, {14{5'b10110}}, 5'b00000}, 5'b01111 },
    '{ {4'b0000, {15{5'b11111}}}, 5'b10000 },
    '{ {4'b1000, {6{5'b01101}}, 5'b00000, {8{5'b00111}}}, 5'b00111 }
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enc_start = 1'b0;
  logic [DATA_W-1:0] enc_data_in = '0;
  logic              enc_done;
  logic [WORD_W-1:0] enc_data_out;
  logic              dec_start = 1'b0;
  logic [WORD_W-1:0] dec_data_in = '0;
  logic              dec_done;
  logic [DATA_W-1:0] dec_data_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  zblk_rll_codec u_zblk_rll_codec (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_start   (enc_start),
    .enc_data_in (enc_data_in),
    .enc_done    (enc_done),
    .enc_data_out(enc_data_out),
    .dec_start   (dec_start),
    .dec_data_in (dec_data_in),
    .dec_done    (dec_done),
    .dec_data_out(dec_data_out)
  );

  // expected coding built from the list of zero slots rather than a running head
  function automatic logic [WORD_W-1:0] model_encode(input logic [DATA_W-1:0] d);
    logic [WORD_W-1:0] w;
    logic [SB_W-1:0]   s [NUM_SB];
    int                zl [NUM_SB];
    int                n;
    logic [SB_W-1:0]   hdr;
    w = {1'b1, d};
    n = 0;
    for (int k = 0; k < NUM_SB; k++) s[k] = w[WORD_W-1-SB_W*k -: SB_W];
    for (int k = 1; k < NUM_SB; k++) if (s[k] == '0) begin zl[n] = k; n++; end
    if (n > 0) begin
      hdr = s[0];
      s[0] = SB_W'(zl[0]);
      for (int j = 0; j < n - 1; j++) s[zl[j]] = SB_W'(zl[j+1]);
      s[zl[n-1]] = hdr;
    end
    for (int k = 0; k < NUM_SB; k++) if (s[k] == '1) s[k] = '0;
    for (int k = 0; k < NUM_SB; k++) w[WORD_W-1-SB_W*k -: SB_W] = s[k];
    return w;
  endfunction

  function automatic bit has_ones(input logic [WORD_W-1:0] w);
    for (int k = 0; k < NUM_SB; k++) if (w[SB_W*k +: SB_W] == '1) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // launch at one edge, watch 2*LAT edges, record first done edge and pulse count
  task automatic run(input bit go_e, input bit go_d,
                     input logic [DATA_W-1:0] ein, input logic [WORD_W-1:0] dwin,
                     input bit poke, output int le, output int ld,
                     output int ne, output int nd);
    @(negedge clk);
    enc_start = go_e; dec_start = go_d;
    enc_data_in = ein; dec_data_in = dwin;
    @(posedge clk);
    @(negedge clk);
    enc_start = 1'b0; dec_start = 1'b0;
    le = -1; ld = -1; ne = 0; nd = 0;
    for (int k = 1; k <= 2 * LAT; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (enc_done) begin ne++; if (le < 0) le = k; end
      if (dec_done) begin nd++; if (ld < 0) ld = k; end
      if (poke && (k == 5 || enc_done || dec_done)) begin
        enc_start = 1'b1; dec_start = 1'b1;
        enc_data_in = ~ein; dec_data_in = ~dwin;
      end else begin
        enc_start = 1'b0; dec_start = 1'b0;
      end
    end
    enc_start = 1'b0; dec_start = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int le, ld, ne, nd;
    logic [WORD_W-1:0] coded, exp_w, held;
    logic [DATA_W-1:0] prev_d, d;
    logic [WORD_W-1:0] prev_c;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk(!enc_done && !dec_done, "R8 reset done", {78'd0, enc_done, dec_done}, '0);
    chk(enc_data_out == '0, "R8 reset enc out", enc_data_out, '0);
    chk(dec_data_out == '0, "R8 reset dec out", {1'b0, dec_data_out}, '0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      exp_w = model_encode(VECS[i].din);
      run(1'b1, 1'b0, VECS[i].din, '0, 1'b0, le, ld, ne, nd);
      coded = enc_data_out;
      chk(coded[WORD_W-1 -: SB_W] == VECS[i].head, "R2 chain head slot",
          {75'd0, coded[WORD_W-1 -: SB_W]}, {75'd0, VECS[i].head});
      chk(coded == exp_w, "R2 pointer chain word", coded, exp_w);
      chk(!has_ones(coded), "R3 no all-ones slot", coded, exp_w);
      chk(le == LAT && ne == 1, "R6 encoder latency", WORD_W'(le), WORD_W'(LAT));
      run(1'b0, 1'b1, '0, coded, 1'b0, le, ld, ne, nd);
      chk(dec_data_out == VECS[i].din, "R4 round trip",
          {1'b0, dec_data_out}, {1'b0, VECS[i].din});
      chk(ld == LAT && nd == 1, "R6 decoder latency", WORD_W'(ld), WORD_W'(LAT));
    end

    // R1 pass-through word with neither kind of special slot
    d = {4'b0110, {15{5'b10011}}};
    run(1'b1, 1'b0, d, '0, 1'b0, le, ld, ne, nd);
    chk(enc_data_out == {1'b1, d}, "R1 pass-through", enc_data_out, {1'b1, d});

    // R5 flag already set: zero slots restored to ones, marker dropped
    run(1'b0, 1'b1, '0, {5'b10110, 5'b00000, {14{5'b01001}}}, 1'b0, le, ld, ne, nd);
    chk(dec_data_out == {4'b0110, 5'b11111, {14{5'b01001}}}, "R5 flag set decode",
        {1'b0, dec_data_out}, {1'b0, 4'b0110, 5'b11111, {14{5'b01001}}});
    run(1'b0, 1'b1, '0, {5'b00000, {15{5'b10010}}}, 1'b0, le, ld, ne, nd);
    chk(dec_data_out == {4'b1111, {15{5'b10010}}}, "R5 mapped header",
        {1'b0, dec_data_out}, {1'b0, 4'b1111, {15{5'b10010}}});

    // R7 start during a pass and in the done cycle, both engines together
    run(1'b1, 1'b1, VECS[6].din, model_encode(VECS[0].din), 1'b1, le, ld, ne, nd);
    chk(ne == 1 && le == LAT, "R7 encoder ignores busy start", WORD_W'(ne), WORD_W'(1));
    chk(nd == 1 && ld == LAT, "R7 decoder ignores busy start", WORD_W'(nd), WORD_W'(1));
    chk(enc_data_out == model_encode(VECS[6].din), "R7 encoder result kept",
        enc_data_out, model_encode(VECS[6].din));
    chk(dec_data_out == VECS[0].din, "R7 decoder result kept",
        {1'b0, dec_data_out}, {1'b0, VECS[0].din});

    // R8 output held while idle
    held = enc_data_out;
    repeat (10) @(negedge clk);
    chk(enc_data_out == held, "R8 encoder output held", enc_data_out, held);

    // R9 concurrent encode of new data and decode of the previous coded word
    prev_d = VECS[2].din;
    prev_c = model_encode(prev_d);
    for (int it = 0; it < 60; it++) begin
      logic [WORD_W-1:0] w;
      w = {1'b1, DATA_W'({$urandom, $urandom, $urandom})};
      for (int k = 1; k < NUM_SB; k++) begin
        int r;
        r = $urandom % 4;
        if (r == 0) w[WORD_W-1-SB_W*k -: SB_W] = '0;
        else if (r == 1) w[WORD_W-1-SB_W*k -: SB_W] = '1;
      end
      d = w[DATA_W-1:0];
      run(1'b1, 1'b1, d, prev_c, 1'b0, le, ld, ne, nd);
      exp_w = model_encode(d);
      chk(enc_data_out == exp_w, "R9 concurrent encode", enc_data_out, exp_w);
      chk(dec_data_out == prev_d, "R9 concurrent decode R4",
          {1'b0, dec_data_out}, {1'b0, prev_d});
      prev_d = d;
      prev_c = enc_data_out;
    end

    summary();
    $finish;
  end
endmodule